// File: doc/BRIEF.md
# Adaptive Tuning-Interval Controller

This block decides how often an external cache tuner is invoked. It counts a programmable interval in clock cycles; when the count runs out it takes an energy sample, pulses a tune request, waits for the tuner to report completion and takes a second energy sample. The relative energy change between the two samples is formed as a Q0.16 fraction and averaged over a power-of-two window of recent tuning events.

The average is mapped to a multiplicative factor by a two-segment piecewise-linear curve that meets at 1.0 on a programmable stability point. A small average change means tuning fires too often, so the interval grows gently by up to the growth gain. A large change means phase changes are being missed, so the interval shrinks sharply down to the shrink gain. The scaled interval is rounded and clamped to a programmable range before the counter reloads. In a periodic workload the interval settles near half the phase length. All arithmetic is fixed-point, and one serial divider is shared between the change ratio and the curve.

Energy samples arrive on a valid/ready stream. `e_ready` is high only while the block waits for the pre-tuning or post-tuning sample. A sample transfers on a cycle where `e_valid` and `e_ready` are both high, and the producer must hold `e_data` steady until then.

Top module: `tune_interval_ctrl`

## Requirements
- R1: Reset leaves `interval_o` at INIT_IVL (64), `factor_o` at 16384 (1.0 in Q2.14), `avg_o` at 0, `tune_req` low and `e_ready` low, and the averaging history all zeros.
- R2: After a reload with value N, `e_ready` rises after max(N,1) clock cycles. After reset it rises exactly INIT_IVL cycles after reset release. `tune_req` is a single-cycle pulse, high in the cycle after the pre-tuning sample is accepted.
- R3: `e_ready` is high only while a pre-tuning or post-tuning sample is awaited. `e_valid` while `e_ready` is low has no effect on any result. `tune_done` has no effect unless a tune request is outstanding.
- R4: The change ratio is 0 when |post−pre| is 0. It is 65536 (1.0 in Q0.16) when |post−pre| ≥ pre. Otherwise it is floor(|post−pre|·65536/pre).
- R5: The block keeps the last 16 ratios. `avg_o` is floor(sum of the newest W ratios / W), where W = 2^min(`win_log2`,4).
- R6: The stability point in Q0.16 is P = 4·`stab_pt`. If `avg_o` < P, then t = ratio(`avg_o`, P) by the R4 rule, and the factor is `up_gain` + floor((16384 − `up_gain`)·t/65536).
- R7: If `avg_o` ≥ P, then t = ratio(`avg_o` − P, 65536 − P) by the R4 rule, and the factor is 16384 + floor((`dn_gain` − 16384)·t/65536). At `avg_o` = P the factor is exactly 1.0.
- R8: The new interval is floor((old·factor + 8192)/16384), raised to `ivl_min` if below it and then lowered to `ivl_max` if above it. It appears on `interval_o` and the factor appears on `factor_o`.
- R9: `interval_o` and the cycle counter hold their values from expiry until the post-tuning sample has been accepted and the new interval computed. Only then does counting restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ivl_min | input | CW | Lower interval bound in cycles |
| ivl_max | input | CW | Upper interval bound in cycles (wins over ivl_min) |
| up_gain | input | 16 | Growth factor at zero change, Q2.14 |
| dn_gain | input | 16 | Shrink factor at full change, Q2.14 |
| stab_pt | input | 16 | Stability point, Q2.14 |
| win_log2 | input | 3 | log2 of averaging window, values above 4 act as 4 |
| e_valid | input | 1 | Energy sample valid |
| e_ready | output | 1 | Energy sample accepted when high with e_valid |
| e_data | input | EW | Energy sample |
| tune_req | output | 1 | One-cycle request to start tuning |
| tune_done | input | 1 | Tuner finished |
| interval_o | output | CW | Current interval in cycles |
| factor_o | output | 16 | Last applied scale factor, Q2.14 |
| avg_o | output | 17 | Windowed average change, Q0.16 |

## Verification
The embedded properties watch every cycle for the following: the tune request is a single pulse that follows an accepted sample, the divider output never exceeds 1.0, the window average stays within 1.0, and each applied factor lies between 1.0 and the gain of its segment. They also check that a freshly loaded interval respects the clamp bounds. Only the bench scenarios can show the exact arithmetic. That covers the rounding of the ratio, average, factor and interval for specific sample pairs, the zero-energy and saturation corners, and the exact stability-point boundary. The scenarios also cover window-length changes, the exact expiry cycle count, and that stray valid or done inputs leave the results untouched.

// File: rtl/tic_pkg.sv
package tic_pkg;
  typedef enum logic [2:0] {
    S_COUNT, S_PRE, S_TUNE, S_POST, S_DIV_E, S_AVG, S_DIV_M, S_APPLY
  } tic_state_e;

  localparam int          FRAC_W  = 17;
  localparam logic [16:0] ONE_Q16 = 17'h10000;
  localparam logic [15:0] ONE_Q14 = 16'h4000;
endpackage

// File: rtl/tic_div.sv
// Serial fractional divider: quo = num/den in Q0.16, saturated at 1.0.
module tic_div #(
  parameter int DW = 18,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [QW:0]   quo
);
  localparam int KW = $clog2(QW + 1);

  logic          busy;
  logic [KW-1:0] steps;
  logic [DW-1:0] rem, den_r, rem_nx;
  logic [QW-1:0] qacc;
  logic [DW:0]   rem2;
  logic          take;

  always_comb begin
    rem2   = {rem, 1'b0};
    take   = rem2 >= {1'b0, den_r};
    rem_nx = take ? DW'(rem2 - {1'b0, den_r}) : rem2[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      steps <= '0;
      rem   <= '0;
      den_r <= '0;
      qacc  <= '0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (num == '0) begin
          quo  <= '0;
          done <= 1'b1;
        end else if (num >= den) begin
          quo  <= {1'b1, {QW{1'b0}}};
          done <= 1'b1;
        end else begin
          busy  <= 1'b1;
          rem   <= num;
          den_r <= den;
          qacc  <= '0;
          steps <= KW'(QW);
        end
      end else if (busy) begin
        rem   <= rem_nx;
        qacc  <= {qacc[QW-2:0], take};
        steps <= steps - 1'b1;
        if (steps == KW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= {1'b0, qacc[QW-2:0], take};
        end
      end
    end
  end

  AST_QUO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quo <= {1'b1, {QW{1'b0}}})); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R4
endmodule

// File: rtl/tic_window.sv
// History of recent change ratios and power-of-two windowed mean.
module tic_window #(
  parameter int FW    = 17,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] din,
  input  logic [2:0]    lg,
  output logic [FW-1:0] avg
);
  import tic_pkg::*;
  localparam int LGD = $clog2(DEPTH);
  localparam int SW  = FW + LGD;

  logic [FW-1:0] hist [DEPTH];
  logic [2:0]    lg_eff;
  logic [SW-1:0] sum;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)    hist[g] <= '0;
        else if (push) hist[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)    hist[g] <= '0;
        else if (push) hist[g] <= hist[g-1];
      end
    end
  end

  always_comb begin
    lg_eff = (lg > 3'(LGD)) ? 3'(LGD) : lg;
    sum    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (32'(i) < (32'd1 << lg_eff)) sum = sum + SW'(hist[i]);
    end
    avg = FW'(sum >> lg_eff);
  end

  AST_AVG_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    avg <= FW'(ONE_Q16)); // R5
endmodule

// File: rtl/tic_map.sv
// Two-segment factor curve and interval scaling with clamp.
module tic_map #(
  parameter int CW = 24,
  parameter int DW = 18
) (
  input  logic [16:0]   avg,
  input  logic [15:0]   up_gain,
  input  logic [15:0]   dn_gain,
  input  logic [15:0]   stab_pt,
  input  logic [16:0]   t,
  input  logic [CW-1:0] old_ivl,
  input  logic [CW-1:0] ivl_min,
  input  logic [CW-1:0] ivl_max,
  output logic          seg_hi,
  output logic [DW-1:0] num,
  output logic [DW-1:0] den,
  output logic [15:0]   y,
  output logic [CW-1:0] new_ivl
);
  import tic_pkg::*;
  localparam int PW = CW + 17;

  logic [17:0]        pos_q16, avg18;
  logic [15:0]        a, b;
  logic signed [16:0] span;
  logic signed [34:0] prod, ysum;
  logic [PW-1:0]      scaled, raw;

  always_comb begin
    pos_q16 = {stab_pt, 2'b00};
    avg18   = {1'b0, avg};
    seg_hi  = avg18 >= pos_q16;
    num     = seg_hi ? DW'(avg18 - pos_q16) : DW'(avg18);
    den     = seg_hi ? DW'(18'h10000 - pos_q16) : DW'(pos_q16);
    a       = seg_hi ? ONE_Q14 : up_gain;
    b       = seg_hi ? dn_gain : ONE_Q14;
    span    = $signed({1'b0, b}) - $signed({1'b0, a});
    prod    = span * $signed({1'b0, t});
    ysum    = $signed(35'({19'b0, a})) + (prod >>> 16);
    y       = ysum[15:0];
    scaled  = PW'(old_ivl) * PW'(y) + PW'(8192);
    raw     = scaled >> 14;
    if (raw < PW'(ivl_min)) raw = PW'(ivl_min);
    if (raw > PW'(ivl_max)) raw = PW'(ivl_max);
    new_ivl = CW'(raw);
  end
endmodule

// File: rtl/tune_interval_ctrl.sv
module tune_interval_ctrl #(
  parameter int CW       = 24,
  parameter int EW       = 16,
  parameter int INIT_IVL = 64,
  parameter int DEPTH    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ivl_min,
  input  logic [CW-1:0] ivl_max,
  input  logic [15:0]   up_gain,
  input  logic [15:0]   dn_gain,
  input  logic [15:0]   stab_pt,
  input  logic [2:0]    win_log2,
  input  logic          e_valid,
  output logic          e_ready,
  input  logic [EW-1:0] e_data,
  output logic          tune_req,
  input  logic          tune_done,
  output logic [CW-1:0] interval_o,
  output logic [15:0]   factor_o,
  output logic [16:0]   avg_o
);
  import tic_pkg::*;
  localparam int DW = (EW > 18) ? EW : 18;

  tic_state_e    st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] pre_r, e_diff;
  logic [16:0]   t_r, quo;
  logic          e_fire, div_start, div_done, push, seg_hi;
  logic [DW-1:0] div_num, div_den, map_num, map_den;
  logic [15:0]   y;
  logic [CW-1:0] new_ivl;

  assign e_ready   = (st == S_PRE) || (st == S_POST);
  assign e_fire    = e_valid && e_ready;
  assign e_diff    = (e_data >= pre_r) ? e_data - pre_r : pre_r - e_data;
  assign div_start = ((st == S_POST) && e_fire) || (st == S_AVG);
  assign div_num   = (st == S_POST) ? DW'(e_diff) : map_num;
  assign div_den   = (st == S_POST) ? DW'(pre_r)  : map_den;
  assign push      = (st == S_DIV_E) && div_done;

  tic_div #(.DW(DW), .QW(16)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(div_den), .done(div_done), .quo(quo)
  );

  tic_window #(.FW(FRAC_W), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .push(push), .din(quo), .lg(win_log2),
    .avg(avg_o)
  );

  tic_map #(.CW(CW), .DW(DW)) u_map (
    .avg(avg_o), .up_gain(up_gain), .dn_gain(dn_gain), .stab_pt(stab_pt),
    .t(t_r), .old_ivl(interval_o), .ivl_min(ivl_min), .ivl_max(ivl_max),
    .seg_hi(seg_hi), .num(map_num), .den(map_den), .y(y), .new_ivl(new_ivl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_COUNT;
      cnt        <= CW'(INIT_IVL);
      interval_o <= CW'(INIT_IVL);
      factor_o   <= ONE_Q14;
      pre_r      <= '0;
      t_r        <= '0;
      tune_req   <= 1'b0;
    end else begin
      tune_req <= 1'b0;
      unique case (st)
        S_COUNT: if (cnt <= CW'(1)) st <= S_PRE;
                 else cnt <= cnt - 1'b1;
        S_PRE:   if (e_fire) begin
                   pre_r    <= e_data;
                   tune_req <= 1'b1;
                   st       <= S_TUNE;
                 end
        S_TUNE:  if (tune_done) st <= S_POST;
        S_POST:  if (e_fire) st <= S_DIV_E;
        S_DIV_E: if (div_done) st <= S_AVG;
        S_AVG:   st <= S_DIV_M;
        S_DIV_M: if (div_done) begin
                   t_r <= quo;
                   st  <= S_APPLY;
                 end
        S_APPLY: begin
                   interval_o <= new_ivl;
                   cnt        <= new_ivl;
                   factor_o   <= y;
                   st         <= S_COUNT;
                 end
        default: st <= S_COUNT;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tune_req |=> !tune_req); // R2
  AST_REQ_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    tune_req |-> $past(e_valid && e_ready)); // R2
  AST_FACTOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_APPLY && !seg_hi) |->
      ((y >= up_gain && y <= ONE_Q14) || (y <= up_gain && y >= ONE_Q14))); // R6
  AST_FACTOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_APPLY && seg_hi) |->
      ((y >= dn_gain && y <= ONE_Q14) || (y <= dn_gain && y >= ONE_Q14))); // R7
  AST_IVL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_APPLY && $past(ivl_min) <= $past(ivl_max)) |->
      (interval_o >= $past(ivl_min) && interval_o <= $past(ivl_max))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TUNE || st == S_POST || st == S_DIV_E || st == S_DIV_M) |=>
      ($stable(cnt) && $stable(interval_o))); // R9
endmodule

// File: tb/tune_interval_ctrl_test.sv
`timescale 1ns/1ps
module tune_interval_ctrl_test;
  localparam int CW = 24;
  localparam int EW = 16;
  localparam int INIT = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] ivl_min = 24'd16, ivl_max = 24'd400;
  logic [15:0]   up_gain = 16'd18022, dn_gain = 16'd8192, stab_pt = 16'd4096;
  logic [2:0]    win_log2 = 3'd2;
  logic          e_valid = 1'b0, tune_done = 1'b0;
  logic [EW-1:0] e_data = '0;
  logic          e_ready, tune_req;
  logic [CW-1:0] interval_o;
  logic [15:0]   factor_o;
  logic [16:0]   avg_o;

  always #2.5 clk = ~clk;

  tune_interval_ctrl #(.CW(CW), .EW(EW), .INIT_IVL(INIT), .DEPTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .ivl_min(ivl_min), .ivl_max(ivl_max),
    .up_gain(up_gain), .dn_gain(dn_gain), .stab_pt(stab_pt),
    .win_log2(win_log2), .e_valid(e_valid), .e_ready(e_ready),
    .e_data(e_data), .tune_req(tune_req), .tune_done(tune_done),
    .interval_o(interval_o), .factor_o(factor_o), .avg_o(avg_o)
  );

  int n_chk = 0, n_fail = 0;
  longint m_ivl = INIT, m_fac = 16384, m_avg = 0;
  longint hist [16];

  localparam logic [31:0] VEC [10] = '{
    32'h03E8_03E8, 32'h03E8_03F2, 32'h07D0_05DC, 32'h01F4_05DC, 32'h9C40_9C40,
    32'h0BB8_0CE4, 32'hFFFF_0000, 32'h04B0_044C, 32'h0320_0334, 32'h000A_000A
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint frac(input longint num, input longint den);
    if (num == 0) return 0;
    if (num >= den) return 65536;
    return (num * 65536) / den;
  endfunction

  task automatic model(input longint pre, input longint post);
    longint d, sum, lg, pos, t, a, b, y, nv;
    d = frac((post > pre) ? post - pre : pre - post, pre);
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    lg = (win_log2 > 4) ? 4 : win_log2;
    sum = 0;
    for (int i = 0; i < (1 << lg); i++) sum += hist[i];
    m_avg = sum >> lg;
    pos = stab_pt * 4;
    if (m_avg >= pos) begin
      t = frac(m_avg - pos, 65536 - pos); a = 16384; b = dn_gain;
    end else begin
      t = frac(m_avg, pos); a = up_gain; b = 16384;
    end
    y = a + (((b - a) * t) >>> 16);
    m_fac = y;
    nv = (m_ivl * y + 8192) >> 14;
    if (nv < ivl_min) nv = ivl_min;
    if (nv > ivl_max) nv = ivl_max;
    m_ivl = nv;
  endtask

  // Waits for the next expiry; a stray tune_done on the way must be ignored (R3).
  task automatic wait_ready(output int lows);
    lows = 0;
    while (!e_ready && lows < 5000) begin
      lows++;
      tune_done = (lows == 5);
      @(negedge clk);
    end
    tune_done = 1'b0;
    if (!e_ready) check("R2 expiry timeout", 0, 1);
  endtask

  task automatic round(input logic [15:0] pre, input logic [15:0] post);
    int lows;
    logic [CW-1:0] held;
    e_valid = 1'b1; e_data = pre;
    @(negedge clk);
    check("R2 tune_req pulse", tune_req, 1);
    check("R3 ready low while tuning", e_ready, 0);
    held = interval_o;
    e_data = 16'hFFFF;                       // valid with ready low: ignored (R3)
    repeat (3) @(negedge clk);
    check("R2 tune_req single cycle", tune_req, 0);
    check("R9 interval held during tuning", interval_o, held);
    e_valid = 1'b0; tune_done = 1'b1;
    @(negedge clk);
    tune_done = 1'b0;
    check("R3 ready for post sample", e_ready, 1);
    e_valid = 1'b1; e_data = post;
    @(negedge clk);
    e_valid = 1'b0;
    model(pre, post);
    wait_ready(lows);
    n_chk++;
    if (lows < m_ivl || lows > m_ivl + 64) begin
      n_fail++;
      $display("FAIL R9 restart delay: actual %0d expected %0d..%0d", lows, m_ivl, m_ivl + 64);
    end
    check("R5 window average", avg_o, m_avg);
    check("R6/R7 factor", factor_o, m_fac);
    check("R8 new interval", interval_o, m_ivl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lows;
    for (int i = 0; i < 16; i++) hist[i] = 0;
    repeat (4) @(negedge clk);
    check("R1 reset interval", interval_o, INIT);
    check("R1 reset factor", factor_o, 16384);
    check("R1 reset average", avg_o, 0);
    check("R1 reset tune_req", tune_req, 0);
    check("R1 reset ready", e_ready, 0);
    rst_n = 1'b1;
    lows = 0;
    while (!e_ready && lows < 5000) begin lows++; @(negedge clk); end
    check("R2 first expiry cycles", lows, INIT);

    // Vector table, window of 4
    for (int v = 0; v < 10; v++) round(VEC[v][31:16], VEC[v][15:0]);

    // Directed corners with a window of 1, so avg_o equals the ratio (R4)
    win_log2 = 3'd0;
    round(16'd0, 16'd0);       // R4 zero/zero gives 0, R6 factor = up_gain
    check("R4 zero change ratio", avg_o, 0);
    check("R6 zero change factor", factor_o, 18022);
    round(16'd0, 16'd7);       // R4 pre zero saturates
    check("R4 saturated ratio", avg_o, 65536);
    check("R7 full change factor", factor_o, 8192);
    round(16'd100, 16'd300);   // R4 diff above pre saturates
    check("R4 large change ratio", avg_o, 65536);
    round(16'd1000, 16'd750);  // R7 exactly at stability point
    check("R4 quarter ratio", avg_o, 16384);
    check("R7 boundary factor", factor_o, 16384);

    // R8 clamp with min == max
    ivl_min = 24'd30; ivl_max = 24'd30;
    round(16'd5, 16'd5);
    check("R8 clamp value", interval_o, 30);
    ivl_min = 24'd20; ivl_max = 24'd1000; up_gain = 16'd32768;
    round(16'd9, 16'd9);
    check("R6 doubled interval", interval_o, 60);

    // R5 window code above 4 acts as 16
    win_log2 = 3'd7; up_gain = 16'd18022;
    round(16'd400, 16'd500);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule